// File: doc/BRIEF.md
# Two-Bank Byte-Lane Access Sequencer

This block turns single byte or word requests from a CPU-side port into bus cycles on a 16-bit data path built from two byte-wide banks. Even byte addresses live in the low bank on data bits 7:0, and odd byte addresses live in the high bank on data bits 15:8. Every bus cycle carries a 20-bit address, an `a0` line that enables the low bank when it is 0, and an active-low `bhe_n` line that enables the high bank. Write data is steered onto the lane that belongs to the target byte, and read data is gathered back into a right-justified result.

A word at an odd address straddles both banks. The block splits it into two bus cycles, high lane first. The first cycle moves the word's low byte through the high bank. The second cycle uses the next address and moves the word's high byte through the low bank. The two small synchronous banks are part of the block. Each bank is indexed by address bits `BANK_IDX_W` down to 1, so the address bits above that range alias.

The request port uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response has been consumed. The response port is also valid/ready: `rsp_valid` and `rsp_rdata` hold steady while `rsp_ready` is low, and the response is consumed on an edge where both are high. Every request, including a write, produces exactly one response.

Top module: `banked_bus_sequencer`

## Requirements
- R1: A byte access at an even address makes one bus cycle with `bus_bhe_n`=1 and `bus_a0`=0. A write drives the data byte on `bus_wdata[7:0]`. In every bus cycle at least one bank is enabled.
- R2: A byte access at an odd address makes one bus cycle with `bus_bhe_n`=0 and `bus_a0`=1. A write drives the data byte on `bus_wdata[15:8]`.
- R3: A word access at an even address makes one bus cycle with `bus_bhe_n`=0 and `bus_a0`=0. A write drives the word's low byte on bits 7:0 and its high byte on bits 15:8.
- R4: A word access at an odd address makes exactly two bus cycles.
  - The first cycle has `bus_addr` equal to the request address, `bus_bhe_n`=0, `bus_a0`=1, and the word's low byte on bits 15:8.
  - The second cycle has `bus_bhe_n`=1, `bus_a0`=0, and the word's high byte on bits 7:0.
- R5: The second cycle of a split word carries the request address plus one, kept to 20 bits. A word at 0xFFFFF therefore reaches 0x00000 in its second cycle.
- R6: Read data is right-justified.
  - A byte read returns the byte in `rsp_rdata[7:0]` with bits 15:8 zero.
  - A word read returns `{byte at address+1, byte at address}`.
  - A write response carries zero.
- R7: A byte write changes only the addressed byte. The other bank's byte at the same word index is unchanged.
- R8: `req_ready` is 1 only when no access is in progress. It stays 0 from the accepting edge until the response is consumed.
- R9: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid` stays 1 and `rsp_rdata` does not change. After the consuming edge, `rsp_valid` is 0 and `req_ready` is 1.
- R10: `rsp_valid` rises on the 2nd clock edge after acceptance for a single-cycle access, and on the 3rd edge for a split word.
- R11: After reset, `req_ready`=1, `bus_valid`=0 and `rsp_valid`=0.
- R12: Each bank stores at word index `bus_addr[BANK_IDX_W:1]`. Two addresses that differ only above bit `BANK_IDX_W` reach the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data, right-justified (a byte uses bits 7:0) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken when high with `rsp_valid` |
| rsp_rdata | output | 16 | Right-justified read data |
| bus_valid | output | 1 | A bus cycle is in progress |
| bus_addr | output | 20 | Bus cycle byte address |
| bus_bhe_n | output | 1 | High-bank enable, active low |
| bus_a0 | output | 1 | Address bit 0; 0 enables the low bank |
| bus_we | output | 1 | Bus cycle writes |
| bus_wdata | output | 16 | Lane-steered write data |

## Verification
Take the accepting clock edge as edge 0. The first bus cycle is visible after edge 0. The second bus cycle of a split word is visible after edge 1. The response is visible after edge 1 for a single-cycle access and after edge 2 for a split word. The bench drives inputs on falling edges and samples at every falling edge after acceptance. At each sample it checks lane enables, address and steered data for whichever bus cycle is showing, and it counts those samples to confirm both the bus-cycle count and the response latency. Read results are compared against a flat byte-array model that wraps at the bank capacity. Held responses are checked at each falling edge while `rsp_ready` is low.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUS1 = 2'd1,
    ST_BUS2 = 2'd2,
    ST_DONE = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              word;
    logic              write;
    logic [DATA_W-1:0] wdata;
  } seq_req_t;
endpackage

// File: rtl/seq_bank_ram.sv
module seq_bank_ram #(
  parameter int IDX_W = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             cs,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [WIDTH-1:0] mem [DEPTH];

  // Read register updates only on a selected read, so it holds otherwise.
  always_ff @(posedge clk) begin
    if (cs) begin
      if (we) mem[idx] <= wdata;
      else    rdata    <= mem[idx];
    end
  end
endmodule

// File: rtl/seq_access_fsm.sv
module seq_access_fsm
  import bus_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_valid,
  input  seq_req_t req_in,
  input  logic     rsp_ready,
  output logic     req_ready,
  output logic     bus_valid,
  output logic     second_cyc,
  output logic     rsp_valid,
  output seq_req_t cur
);
  seq_state_e state, state_nx;
  logic       split;

  assign split = cur.word & cur.addr[0];

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (req_valid) state_nx = ST_BUS1;
      ST_BUS1: state_nx = split ? ST_BUS2 : ST_DONE;
      ST_BUS2: state_nx = ST_DONE;
      ST_DONE: if (rsp_ready) state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_IDLE && req_valid) cur <= req_in;
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign bus_valid  = (state == ST_BUS1) || (state == ST_BUS2);
  assign second_cyc = (state == ST_BUS2);
  assign rsp_valid  = (state == ST_DONE);

  AST_REQ_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(cur)); // R8
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid); // R9
  AST_SPLIT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUS1 && cur.word && cur.addr[0]) |=> second_cyc); // R4
  AST_ALIGNED_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUS1 && !(cur.word && cur.addr[0])) |=> rsp_valid); // R10
endmodule

// File: rtl/seq_lane_steer.sv
module seq_lane_steer
  import bus_seq_pkg::*;
(
  input  seq_req_t          cur,
  input  logic              second_cyc,
  input  logic              done,
  input  logic [LANE_W-1:0] lo_q,
  input  logic [LANE_W-1:0] hi_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_bhe_n,
  output logic              bus_a0,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [LANE_W-1:0] lo_lane, hi_lane;
  logic              odd;

  assign odd       = cur.addr[0];
  assign bus_addr  = second_cyc ? ADDR_W'(cur.addr + 1'b1) : cur.addr;
  assign bus_a0    = bus_addr[0];
  assign bus_bhe_n = second_cyc ? 1'b1 : (cur.word ? 1'b0 : ~odd);

  always_comb begin
    lo_lane = '0;
    hi_lane = '0;
    if (second_cyc) begin
      lo_lane = cur.wdata[DATA_W-1:LANE_W];
    end else if (cur.word && !odd) begin
      lo_lane = cur.wdata[LANE_W-1:0];
      hi_lane = cur.wdata[DATA_W-1:LANE_W];
    end else if (odd) begin
      hi_lane = cur.wdata[LANE_W-1:0];
    end else begin
      lo_lane = cur.wdata[LANE_W-1:0];
    end
  end
  assign bus_wdata = {hi_lane, lo_lane};

  // The high bank is idle in the second cycle of a split word, so its
  // read register still holds the word's low byte at response time.
  always_comb begin
    rsp_rdata = '0;
    if (done && !cur.write) begin
      if (!cur.word)  rsp_rdata = {{LANE_W{1'b0}}, odd ? hi_q : lo_q};
      else if (odd)   rsp_rdata = {lo_q, hi_q};
      else            rsp_rdata = {hi_q, lo_q};
    end
  end
endmodule

// File: rtl/banked_bus_sequencer.sv
module banked_bus_sequencer
  import bus_seq_pkg::*;
#(
  parameter int BANK_IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_bhe_n,
  output logic              bus_a0,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata
);
  localparam int LANES = DATA_W / LANE_W;

  seq_req_t          req_in, cur;
  logic              second_cyc;
  logic [LANE_W-1:0] bank_q [LANES];
  logic [LANES-1:0]  bank_cs;

  assign req_in = '{addr: req_addr, word: req_word, write: req_write, wdata: req_wdata};

  seq_access_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_in     (req_in),
    .rsp_ready  (rsp_ready),
    .req_ready  (req_ready),
    .bus_valid  (bus_valid),
    .second_cyc (second_cyc),
    .rsp_valid  (rsp_valid),
    .cur        (cur)
  );

  seq_lane_steer u_steer (
    .cur        (cur),
    .second_cyc (second_cyc),
    .done       (rsp_valid),
    .lo_q       (bank_q[0]),
    .hi_q       (bank_q[1]),
    .bus_addr   (bus_addr),
    .bus_bhe_n  (bus_bhe_n),
    .bus_a0     (bus_a0),
    .bus_wdata  (bus_wdata),
    .rsp_rdata  (rsp_rdata)
  );

  assign bus_we     = bus_valid & cur.write;
  assign bank_cs[0] = bus_valid & ~bus_a0;
  assign bank_cs[1] = bus_valid & ~bus_bhe_n;

  for (genvar g = 0; g < LANES; g++) begin : g_bank
    seq_bank_ram #(.IDX_W(BANK_IDX_W), .WIDTH(LANE_W)) u_bank (
      .clk   (clk),
      .cs    (bank_cs[g]),
      .we    (bus_we),
      .idx   (bus_addr[BANK_IDX_W:1]),
      .wdata (bus_wdata[g*LANE_W +: LANE_W]),
      .rdata (bank_q[g])
    );
  end

  AST_SOME_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> !(bus_bhe_n && bus_a0)); // R1
  AST_SECOND_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    second_cyc |-> (bus_bhe_n && !bus_a0)); // R4
  AST_SECOND_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    second_cyc |-> (bus_addr == ADDR_W'($past(bus_addr) + 1'b1))); // R5
  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> $stable(rsp_rdata)); // R9
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cur.word) |-> (rsp_rdata[DATA_W-1:LANE_W] == '0)); // R6
  AST_NO_BUS_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> (bus_valid && !req_ready)); // R8
endmodule

// File: tb/banked_bus_sequencer_tb.sv
module banked_bus_sequencer_tb;
  localparam int IDXW = 8;
  localparam int MSZ  = 1 << (IDXW + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_word = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        req_ready, rsp_valid, bus_valid, bus_bhe_n, bus_a0, bus_we;
  logic [15:0] rsp_rdata, bus_wdata;
  logic [19:0] bus_addr;

  int errors = 0;
  int checks = 0;
  logic [7:0] model [MSZ];

  always #2 clk = ~clk;

  banked_bus_sequencer #(.BANK_IDX_W(IDXW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_word(req_word), .req_write(req_write),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_rdata(rsp_rdata), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_bhe_n(bus_bhe_n), .bus_a0(bus_a0), .bus_we(bus_we), .bus_wdata(bus_wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int midx(input logic [19:0] a);
    return int'(a[IDXW:0]);
  endfunction

  task automatic access(input logic [19:0] a, input bit w, input bit wr,
                        input logic [15:0] d, input int hold);
    logic [19:0] a1;
    logic [15:0] exp_rd;
    string       rq;
    int          lat, nbus, want_bus;
    a1 = 20'(a + 1'b1);
    want_bus = (w && a[0]) ? 2 : 1;
    rq = w ? (a[0] ? "R4" : "R3") : (a[0] ? "R2" : "R1");
    if (wr)     exp_rd = 16'h0;
    else if (w) exp_rd = {model[midx(a1)], model[midx(a)]};
    else        exp_rd = {8'h00, model[midx(a)]};
    @(negedge clk);
    chk("R8 idle ready", {31'b0, req_ready}, 32'd1);
    req_addr = a; req_word = w; req_write = wr; req_wdata = d;
    req_valid = 1'b1; rsp_ready = (hold == 0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1; nbus = 0;
    for (int k = 0; k < 8; k++) begin
      if (req_ready) chk("R8 busy ready", {31'b0, req_ready}, 32'd0);
      if (bus_valid) begin
        nbus++;
        chk({rq, " bus_we"}, {31'b0, bus_we}, {31'b0, wr});
        if (nbus == 1) begin
          chk({rq, " addr1"}, {12'b0, bus_addr}, {12'b0, a});
          chk({rq, " bhe_n"}, {31'b0, bus_bhe_n}, {31'b0, (w ? 1'b0 : ~a[0])});
          chk({rq, " a0"}, {31'b0, bus_a0}, {31'b0, a[0]});
          if (wr) begin
            if (w && !a[0])  chk("R3 lanes", {16'b0, bus_wdata}, {16'b0, d});
            else if (a[0])   chk({rq, " hi lane"}, {24'b0, bus_wdata[15:8]}, {24'b0, d[7:0]});
            else             chk("R1 lo lane", {24'b0, bus_wdata[7:0]}, {24'b0, d[7:0]});
          end
        end else begin
          chk("R5 addr2", {12'b0, bus_addr}, {12'b0, a1});
          chk("R4 bhe_n2", {31'b0, bus_bhe_n}, 32'd1);
          chk("R4 a0_2", {31'b0, bus_a0}, 32'd0);
          if (wr) chk("R4 lo lane2", {24'b0, bus_wdata[7:0]}, {24'b0, d[15:8]});
        end
      end
      if (rsp_valid) break;
      @(negedge clk);
      lat++;
    end
    chk({rq, " R10 latency"}, lat, (want_bus == 2) ? 3 : 2);
    chk({rq, " bus cycles"}, nbus, want_bus);
    chk("R6 rdata", {16'b0, rsp_rdata}, {16'b0, exp_rd});
    if (hold > 0) begin
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk("R9 held valid", {31'b0, rsp_valid}, 32'd1);
        chk("R9 held data", {16'b0, rsp_rdata}, {16'b0, exp_rd});
        chk("R8 held ready", {31'b0, req_ready}, 32'd0);
      end
      rsp_ready = 1'b1;
      @(negedge clk);
      chk("R9 consumed", {30'b0, rsp_valid, req_ready}, 32'd1);
    end
    if (wr) begin
      model[midx(a)] = d[7:0];
      if (w) model[midx(a1)] = d[15:8];
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset state", {29'b0, req_ready, bus_valid, rsp_valid}, 32'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 after release", {29'b0, req_ready, bus_valid, rsp_valid}, 32'd4);

    // R3: fill both banks with aligned word writes
    for (int i = 0; i < MSZ; i += 2)
      access(20'(i), 1'b1, 1'b1, 16'(((i * 37) + 5) ^ ((i + 1) << 8)), 0);
    // R1/R2: byte writes over a window, then R7 check through word reads
    for (int i = 0; i < 64; i++)
      access(20'(i), 1'b0, 1'b1, 16'(8'(i * 11 + 3)), 0);
    for (int i = 0; i < 64; i += 2)
      access(20'(i), 1'b1, 1'b0, 16'h0, 0); // R7 untouched neighbours
    // R4: split word writes at odd addresses
    for (int i = 65; i < 129; i += 2)
      access(20'(i), 1'b1, 1'b1, 16'(i * 263 + 17), 0);
    // R6: full read sweeps, byte and word, every address
    for (int i = 0; i < MSZ; i++) access(20'(i), 1'b0, 1'b0, 16'h0, 0);
    for (int i = 0; i < MSZ; i++) access(20'(i), 1'b1, 1'b0, 16'h0, 0);
    // R5: wrap at the top of the address space
    access(20'hFFFFF, 1'b1, 1'b1, 16'hA55A, 0);
    access(20'hFFFFF, 1'b1, 1'b0, 16'h0, 0);
    access(20'h00000, 1'b0, 1'b0, 16'h0, 0);
    // R12: alias above the bank index
    access(20'h00010, 1'b1, 1'b1, 16'hBEEF, 0);
    access(20'h7A410, 1'b1, 1'b0, 16'h0, 0);
    access(20'h34213, 1'b0, 1'b1, 16'h00C3, 0);
    access(20'h00213, 1'b0, 1'b0, 16'h0, 0);
    // R9: held responses for read, split read and write
    access(20'h00021, 1'b1, 1'b0, 16'h0, 3);
    access(20'h00040, 1'b0, 1'b0, 16'h0, 2);
    access(20'h00051, 1'b1, 1'b1, 16'h1234, 4);
    access(20'h00051, 1'b1, 1'b0, 16'h0, 1);
    finish_run();
  end
endmodule